// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is one bank of general-purpose pins behind a small register port. Software reaches it with a byte address, a write strobe, write data and read data that returns a value in the same cycle. For each pin the block holds a drive value and a drive enable, a pull resistor enable and direction, and an interrupt detector. The pad itself sits outside the block. The block hands the pad its drive and pull controls and takes the pad's raw input back.

Each pin input passes through a two-stage synchronizer. The synchronized value can be read back, and it feeds the interrupt detector. Three per-pin control bits set the detector. The sense bit picks level or edge. The both-edges bit makes an edge-sensed pin fire on any change. The polarity bit picks high or rising when 1, and low or falling when 0. A detected event sets a sticky raw status bit, which software clears by writing ones to the acknowledge register. A per-pin enable mask gives a masked status, and the single interrupt line is the OR of that masked status.

Top module: `gpio_irq_bank`

Register offsets (byte address, 32-bit words): 0x00 drive value, 0x04 drive enable, 0x08 pull enable, 0x0C pull direction, 0x10 synchronized pin level (read-only), 0x14 sense mode, 0x18 polarity, 0x1C both-edges, 0x20 interrupt enable mask, 0x24 raw status (read-only), 0x28 masked status (read-only), 0x2C acknowledge (write-one-to-clear, reads 0). Bit n of each register belongs to pin n.

## Requirements
- R1: After reset every register reads 0, all drive enables and pull controls are 0, and `irq` is 0.
- R2: The drive value (0x00) and drive enable (0x04) registers read back what was written and appear on `pin_out` and `pin_oe` one cycle after the write. A drive enable of 1 makes the pin an output.
- R3: `pull_up_en` is pull enable AND pull direction, and `pull_dn_en` is pull enable AND NOT pull direction (direction 1 = up). A direction bit has no effect while its enable bit is 0.
- R4: The level register (0x10) shows `pin_in` two clock edges after it changes, and writes to it are ignored.
- R5: With sense bit 0 and both-edges bit 0, a pin with polarity 1 latches status on a rising input and a pin with polarity 0 latches on a falling input. The raw status bit reads 1 on the third clock edge after the pin changes and not before.
- R6: With sense bit 0 and both-edges bit 1, both rising and falling inputs latch status, whatever the polarity bit holds.
- R7: With sense bit 1, raw status is set on every cycle that the synchronized level equals the polarity bit. An acknowledge while that level persists leaves the bit set, and an acknowledge after the level has gone clears it.
- R8: Edge status stays latched until a 1 is written to its bit of the acknowledge register. Writing 0 bits leaves the status unchanged, and the acknowledge register reads 0.
- R9: Masked status (0x28) equals raw status AND the enable mask (0x20), and `irq` is 1 exactly when any masked status bit is 1.
- R10: Writes to the raw status and masked status addresses are ignored.
- R11: A read from an address not in the map returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| pin_in | input | 32 | Raw pad inputs |
| pin_out | output | 32 | Drive value to pads |
| pin_oe | output | 32 | Drive enable to pads |
| pull_up_en | output | 32 | Pull-up request per pad |
| pull_dn_en | output | 32 | Pull-down request per pad |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check on every cycle that any detector event lands in raw status on the next edge, and that a status bit only falls where an acknowledge asked for it. They also check that an acknowledge with no competing event leaves the bit clear, that any change on a both-edges pin counts as an event, and that drive-enable and pull writes take effect on the next edge. Only the bench scenarios can show the full sense truth table. They also show the exact three-edge latency from pad to status, level status re-arming against an acknowledge, masking, and the ignored writes and unmapped reads.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned OFS_DOUT  = 'h00;
  localparam int unsigned OFS_OE    = 'h04;
  localparam int unsigned OFS_PEN   = 'h08;
  localparam int unsigned OFS_PDIR  = 'h0C;
  localparam int unsigned OFS_LEVEL = 'h10;
  localparam int unsigned OFS_SENSE = 'h14;
  localparam int unsigned OFS_POL   = 'h18;
  localparam int unsigned OFS_BOTH  = 'h1C;
  localparam int unsigned OFS_MASK  = 'h20;
  localparam int unsigned OFS_RAW   = 'h24;
  localparam int unsigned OFS_MSTAT = 'h28;
  localparam int unsigned OFS_ACK   = 'h2C;

  // One pin's detector decision for the current cycle.
  function automatic logic sense_hit(input logic lvl, input logic both,
                                     input logic pol, input logic cur,
                                     input logic prv);
    logic hit;
    if (lvl)       hit = (cur == pol);
    else if (both) hit = (cur != prv);
    else if (pol)  hit = cur & ~prv;
    else           hit = ~cur & prv;
    return hit;
  endfunction

  // Sticky status update: new events win over an acknowledge.
  function automatic logic [31:0] status_next(input logic [31:0] cur,
                                              input logic [31:0] ack,
                                              input logic [31:0] hit);
    return (cur & ~ack) | hit;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_edge_sense.sv
module gpio_edge_sense
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] lvl,
  input  logic [WIDTH-1:0] both,
  input  logic [WIDTH-1:0] pol,
  output logic [WIDTH-1:0] prev_q,
  output logic [WIDTH-1:0] hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign hit[i] = sense_hit(lvl[i], both[i], pol[i], cur[i], prev_q[i]);
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [NPINS-1:0]  wr_data,
  output logic [NPINS-1:0]  rd_data,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pull_up_en,
  output logic [NPINS-1:0]  pull_dn_en,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_DOUT  = ADDR_W'(OFS_DOUT);
  localparam logic [ADDR_W-1:0] A_OE    = ADDR_W'(OFS_OE);
  localparam logic [ADDR_W-1:0] A_PEN   = ADDR_W'(OFS_PEN);
  localparam logic [ADDR_W-1:0] A_PDIR  = ADDR_W'(OFS_PDIR);
  localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(OFS_LEVEL);
  localparam logic [ADDR_W-1:0] A_SENSE = ADDR_W'(OFS_SENSE);
  localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(OFS_POL);
  localparam logic [ADDR_W-1:0] A_BOTH  = ADDR_W'(OFS_BOTH);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(OFS_MSTAT);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFS_ACK);

  logic [NPINS-1:0] dout_q, oe_q, pen_q, pdir_q;
  logic [NPINS-1:0] lvl_q, pol_q, both_q, mask_q, raw_q;
  logic [NPINS-1:0] sync_q, prev_q, hit_vec, ack_vec, masked;

  gpio_sync #(.WIDTH(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
  );

  gpio_edge_sense #(.WIDTH(NPINS)) u_sense (
    .clk(clk), .rst_n(rst_n), .cur(sync_q), .lvl(lvl_q),
    .both(both_q), .pol(pol_q), .prev_q(prev_q), .hit(hit_vec)
  );

  assign ack_vec = (wr_en && addr == A_ACK) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0; oe_q  <= '0; pen_q  <= '0; pdir_q <= '0;
      lvl_q  <= '0; pol_q <= '0; both_q <= '0; mask_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DOUT:  dout_q <= wr_data;
        A_OE:    oe_q   <= wr_data;
        A_PEN:   pen_q  <= wr_data;
        A_PDIR:  pdir_q <= wr_data;
        A_SENSE: lvl_q  <= wr_data;
        A_POL:   pol_q  <= wr_data;
        A_BOTH:  both_q <= wr_data;
        A_MASK:  mask_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= NPINS'(status_next(32'(raw_q), 32'(ack_vec), 32'(hit_vec)));
  end

  assign masked = raw_q & mask_q;
  assign irq    = |masked;

  assign pin_out    = dout_q;
  assign pin_oe     = oe_q;
  assign pull_up_en = pen_q & pdir_q;
  assign pull_dn_en = pen_q & ~pdir_q;

  always_comb begin
    case (addr)
      A_DOUT:  rd_data = dout_q;
      A_OE:    rd_data = oe_q;
      A_PEN:   rd_data = pen_q;
      A_PDIR:  rd_data = pdir_q;
      A_LEVEL: rd_data = sync_q;
      A_SENSE: rd_data = lvl_q;
      A_POL:   rd_data = pol_q;
      A_BOTH:  rd_data = both_q;
      A_MASK:  rd_data = mask_q;
      A_RAW:   rd_data = raw_q;
      A_MSTAT: rd_data = masked;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [NPINS-1:0]  wr_data,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  pull_up_en,
  input logic [NPINS-1:0]  pull_dn_en,
  input logic              irq,
  input logic [NPINS-1:0]  raw_q,
  input logic [NPINS-1:0]  mask_q,
  input logic [NPINS-1:0]  hit_vec,
  input logic [NPINS-1:0]  ack_vec,
  input logic [NPINS-1:0]  sync_q,
  input logic [NPINS-1:0]  prev_q,
  input logic [NPINS-1:0]  lvl_q,
  input logic [NPINS-1:0]  both_q
);
  localparam logic [ADDR_W-1:0] A_OE  = ADDR_W'(gpio_bank_pkg::OFS_OE);
  localparam logic [ADDR_W-1:0] A_PEN = ADDR_W'(gpio_bank_pkg::OFS_PEN);

  assert_oe_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_OE) |=> (pin_oe == $past(wr_data)));

  assert_pull_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PEN && wr_data == '0) |=> (pull_up_en == '0 && pull_dn_en == '0));

  assert_event_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |=> ((raw_q & $past(hit_vec)) == $past(hit_vec)));

  assert_dual_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (((sync_q ^ prev_q) & both_q & ~lvl_q & ~hit_vec) == '0));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(raw_q) & ~raw_q & ~$past(ack_vec)) == '0));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec != '0) |=> ((raw_q & $past(ack_vec & ~hit_vec)) == '0));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_q != '0 && mask_q != '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .pin_oe(pin_oe), .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en),
  .irq(irq), .raw_q(raw_q), .mask_q(mask_q), .hit_vec(hit_vec),
  .ack_vec(ack_vec), .sync_q(sync_q), .prev_q(prev_q), .lvl_q(lvl_q),
  .both_q(both_q)
);

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  localparam logic [7:0] DOUT = 8'h00, OE = 8'h04, PEN = 8'h08, PDIR = 8'h0C,
                         LEVEL = 8'h10, SENSE = 8'h14, POL = 8'h18, BOTH = 8'h1C,
                         MASK = 8'h20, RAW = 8'h24, MSTAT = 8'h28, ACK = 8'h2C;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, irq;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0, rd_data, pin_in = '0, pin_out, pin_oe, pull_up_en, pull_dn_en;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    logic [31:0] any = '0;
    logic [31:0] v;
    for (int a = 0; a <= 'h2C; a += 4) begin
      rd(8'(a), v);
      any |= v;
    end
    check("R1 regs", any, 0);
    check("R1 oe", pin_oe, 0);
    check("R1 pull", pull_up_en | pull_dn_en, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_drive;
    wr(DOUT, 32'hA5A5_0F0F);
    wr(OE, 32'hFFFF_0000);
    check("R2 pin_out", pin_out, 32'hA5A5_0F0F);
    check("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    rd_check("R2 dout rb", DOUT, 32'hA5A5_0F0F);
    rd_check("R2 oe rb", OE, 32'hFFFF_0000);
  endtask

  task automatic t_pull;
    wr(PEN, 32'h0000_00FF);
    wr(PDIR, 32'hF000_000F);
    check("R3 up", pull_up_en, 32'h0000_000F);
    check("R3 dn", pull_dn_en, 32'h0000_00F0);
    rd_check("R3 dir rb", PDIR, 32'hF000_000F);
  endtask

  task automatic t_input;
    pin_in = 32'h1234_5678;
    tick(1);
    rd_check("R4 one edge", LEVEL, 32'h0);
    tick(1);
    rd_check("R4 two edges", LEVEL, 32'h1234_5678);
    wr(LEVEL, 32'hFFFF_FFFF);
    rd_check("R4 write ignored", LEVEL, 32'h1234_5678);
    pin_in = '0;
    tick(4);
    // falling edges latched on default polarity 0
    rd_check("R5 falling default", RAW, 32'h1234_5678);
    wr(ACK, 32'hFFFF_FFFF);
    rd_check("R8 ack all", RAW, 32'h0);
    rd_check("R8 ack reads 0", ACK, 32'h0);
  endtask

  task automatic t_edge;
    wr(POL, 32'h0000_0008);
    wr(MASK, 32'h0000_0018);
    pin_in = 32'h0000_0018;
    tick(2);
    rd_check("R5 not before third edge", RAW, 32'h0);
    tick(1);
    rd_check("R5 rising pol1", RAW, 32'h0000_0008);
    check("R9 irq set", {31'b0, irq}, 1);
    pin_in = 32'h0;
    tick(3);
    rd_check("R5 falling pol0", RAW, 32'h0000_0018);
    wr(ACK, 32'h0);
    rd_check("R8 zero ack", RAW, 32'h0000_0018);
    wr(ACK, 32'h0000_0008);
    rd_check("R8 ack one bit", RAW, 32'h0000_0010);
    wr(ACK, 32'h0000_0010);
    rd_check("R8 ack last", RAW, 32'h0);
    check("R9 irq clear", {31'b0, irq}, 0);
  endtask

  task automatic t_dual;
    wr(BOTH, 32'h0000_0080);
    pin_in = 32'h0000_0080;
    tick(3);
    rd_check("R6 rise pol0", RAW, 32'h0000_0080);
    wr(ACK, 32'h0000_0080);
    wr(POL, 32'h0000_0080);
    pin_in = 32'h0;
    tick(3);
    rd_check("R6 fall pol1", RAW, 32'h0000_0080);
    wr(ACK, 32'h0000_0080);
    wr(BOTH, 32'h0);
    wr(POL, 32'h0);
    rd_check("R6 cleaned", RAW, 32'h0);
  endtask

  task automatic t_level;
    wr(POL, 32'h0000_0200);
    wr(SENSE, 32'h0000_0200);
    pin_in = 32'h0000_0200;
    tick(3);
    rd_check("R7 high level", RAW, 32'h0000_0200);
    wr(ACK, 32'h0000_0200);
    rd_check("R7 ack while active", RAW, 32'h0000_0200);
    pin_in = 32'h0;
    tick(3);
    wr(ACK, 32'h0000_0200);
    tick(2);
    rd_check("R7 ack after level gone", RAW, 32'h0);
    wr(SENSE, 32'h0000_0600);
    tick(1);
    rd_check("R7 low level pol0", RAW, 32'h0000_0400);
    wr(SENSE, 32'h0);
    wr(ACK, 32'hFFFF_FFFF);
    rd_check("R7 cleaned", RAW, 32'h0);
    wr(POL, 32'h0);
  endtask

  task automatic t_mask;
    wr(MASK, 32'h0);
    pin_in = 32'h0000_F000;
    tick(2);
    pin_in = 32'h0;
    tick(3);
    rd_check("R9 raw", RAW, 32'h0000_F000);
    rd_check("R9 masked off", MSTAT, 32'h0);
    check("R9 irq masked", {31'b0, irq}, 0);
    wr(MASK, 32'h0000_3000);
    rd_check("R9 masked part", MSTAT, 32'h0000_3000);
    check("R9 irq on", {31'b0, irq}, 1);
    wr(RAW, 32'h0);
    wr(MSTAT, 32'h0);
    rd_check("R10 raw write ignored", RAW, 32'h0000_F000);
    rd_check("R10 masked write ignored", MSTAT, 32'h0000_3000);
    rd_check("R11 unmapped", 8'h40, 32'h0);
    rd_check("R11 misaligned", 8'h05, 32'h0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_drive();
    t_pull();
    t_input();
    t_edge();
    t_dual();
    t_level();
    t_mask();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule